// File: doc/BRIEF.md
# Bit-Sliced Ripple ALU

This block is a purely combinational arithmetic-logic unit for a simple processor datapath. It is assembled from one-bit slices linked by a ripple carry chain. Each slice can invert its A operand, invert its B operand, and pass one of four candidates to its result bit: the bitwise AND, the bitwise OR, the full-adder sum, or a per-slice "less" input.

A 4-bit control word selects the function. Bit 3 inverts A. Bit 2 inverts B and also forces the carry into slice 0 to 1. Bits 1:0 pick the slice output: 00 AND, 01 OR, 10 sum, 11 less. Six control words are the named operations, and every other word follows the same field rules.

For set-less-than, the top slice computes the signed comparison from its sum bit and its overflow. That comparison drives the less input of slice 0. The less inputs of all other slices are held at zero. A Zero flag reports an all-zero result, and an Overflow flag reports signed overflow of the adder.

Top module: `sliced_alu`

## Requirements
- R1: Control 0000 gives result = A AND B.
- R2: Control 0001 gives result = A OR B.
- R3: Control 0010 gives result = (A + B) modulo 2^32.
- R4: Control 0110 gives result = (A − B) modulo 2^32.
- R5: Control 0111 gives result 1 when A < B as signed two's-complement values and 0 otherwise, with bits 31:1 always 0. The answer is correct even when A − B overflows.
- R6: Control 1100 gives result = NOT (A OR B).
- R7: The zero output is 1 exactly when all 32 result bits are 0.
- R8: With control 0010, overflow is 1 exactly when A and B have the same sign and the sum's sign differs from it.
- R9: With control 0110, overflow is 1 exactly when A and B have different signs and the difference's sign differs from A's sign.
- R10: Overflow is 0 whenever control bits 1:0 are not 10 (AND, OR, NOR, set-less-than).
- R11: Any other control word follows the field rules. Bit 3 inverts A and bit 2 inverts B, with carry-in equal to bit 2. Example: 1010 gives NOT A + B, and 0100 gives A AND NOT B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| ctrl | input | 4 | Control: [3] invert A, [2] invert B with carry-in, [1:0] output select |
| result | output | 32 | Function result |
| zero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow of add/subtract; 0 otherwise |

## Verification
The block holds no state. A fault therefore shows at the ports in the same evaluation as the inputs that expose it, and it never lingers across later inputs.

Each kind of fault shows up on a specific input pattern:
- A break in the carry chain shows only on operands whose carry runs past the broken slice, such as all-ones plus one.
- A wrong feedback from the top slice into bit 0 appears as a flipped set-less-than answer. It is only visible on operand pairs whose subtraction overflows.
- A wrong overflow gating shows up as a spurious flag on logical operations.

The vectors are chosen so that each of these paths is exercised.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } alu_sel_e;

    typedef struct packed {
        logic     inv_a;
        logic     inv_b;
        alu_sel_e sel;
    } alu_ctrl_t;

    typedef struct packed {
        logic sum;
        logic cout;
        logic res;
    } slice_out_t;

    // Shared one-bit datapath: conditional inversion, full adder, output mux.
    function automatic slice_out_t slice_eval(input logic a, input logic b,
                                              input logic inv_a, input logic inv_b,
                                              input logic cin, input logic less,
                                              input alu_sel_e sel);
        slice_out_t o;
        logic ae, be;
        ae     = a ^ inv_a;
        be     = b ^ inv_b;
        o.sum  = ae ^ be ^ cin;
        o.cout = (ae & be) | (ae & cin) | (be & cin);
        case (sel)
            SEL_AND: o.res = ae & be;
            SEL_OR:  o.res = ae | be;
            SEL_SUM: o.res = o.sum;
            default: o.res = less;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/alu_slice.sv
module alu_slice
    import alu_pkg::*;
(
    input  logic     a_i,
    input  logic     b_i,
    input  logic     inv_a_i,
    input  logic     inv_b_i,
    input  logic     cin_i,
    input  logic     less_i,
    input  alu_sel_e sel_i,
    output logic     res_o,
    output logic     cout_o
);
    slice_out_t out_d;

    always_comb begin
        out_d = slice_eval(a_i, b_i, inv_a_i, inv_b_i, cin_i, less_i, sel_i);
    end

    assign res_o  = out_d.res;
    assign cout_o = out_d.cout;
endmodule

// File: rtl/alu_msb_slice.sv
module alu_msb_slice
    import alu_pkg::*;
(
    input  logic     a_i,
    input  logic     b_i,
    input  logic     inv_a_i,
    input  logic     inv_b_i,
    input  logic     cin_i,
    input  logic     less_i,
    input  alu_sel_e sel_i,
    output logic     res_o,
    output logic     set_o,
    output logic     ovf_o
);
    slice_out_t out_d;

    always_comb begin
        out_d = slice_eval(a_i, b_i, inv_a_i, inv_b_i, cin_i, less_i, sel_i);
    end

    // Signed overflow: carry into the sign position differs from carry out.
    assign ovf_o = cin_i ^ out_d.cout;
    // True signed "less" = sign of difference corrected by overflow.
    assign set_o = out_d.sum ^ ovf_o;
    assign res_o = out_d.res;
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] val_i,
    output logic             zero_o
);
    assign zero_o = ~(|val_i);
endmodule

// File: rtl/sliced_alu.sv
module sliced_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [3:0]       ctrl,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             overflow
);
    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] result;
        logic             zero;
        logic             overflow;
    } alu_out_t;

    alu_ctrl_t        ctl;
    logic [WIDTH-1:0] carry;
    logic [WIDTH-1:0] less;
    logic [WIDTH-1:0] slice_res;
    logic             set_msb;
    logic             ovf_msb;
    logic             zero_raw;
    alu_out_t         out_d;

    assign ctl      = alu_ctrl_t'(ctrl);
    assign carry[0] = ctl.inv_b;
    assign less     = {{(WIDTH-1){1'b0}}, set_msb};

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        if (i == MSB) begin : g_top
            alu_msb_slice u_msb (
                .a_i     (op_a[i]),
                .b_i     (op_b[i]),
                .inv_a_i (ctl.inv_a),
                .inv_b_i (ctl.inv_b),
                .cin_i   (carry[i]),
                .less_i  (less[i]),
                .sel_i   (ctl.sel),
                .res_o   (slice_res[i]),
                .set_o   (set_msb),
                .ovf_o   (ovf_msb)
            );
        end else begin : g_low
            alu_slice u_bit (
                .a_i     (op_a[i]),
                .b_i     (op_b[i]),
                .inv_a_i (ctl.inv_a),
                .inv_b_i (ctl.inv_b),
                .cin_i   (carry[i]),
                .less_i  (less[i]),
                .sel_i   (ctl.sel),
                .res_o   (slice_res[i]),
                .cout_o  (carry[i+1])
            );
        end
    end

    alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
        .val_i  (slice_res),
        .zero_o (zero_raw)
    );

    always_comb begin
        out_d          = '0;
        out_d.result   = slice_res;
        out_d.zero     = zero_raw;
        out_d.overflow = (ctl.sel == SEL_SUM) ? ovf_msb : 1'b0;
    end

    assign result   = out_d.result;
    assign zero     = out_d.zero;
    assign overflow = out_d.overflow;
endmodule

// File: rtl/sliced_alu_props.sv
module sliced_alu_props #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [3:0]       ctrl,
    input logic [WIDTH-1:0] result,
    input logic             zero,
    input logic             overflow
);
    always_comb begin
        assert_zero_flag_R7: assert (zero == (result == '0));
        if (ctrl[1:0] != 2'b10) begin
            assert_no_overflow_R10: assert (!overflow);
        end
        if (ctrl == 4'b0111) begin
            assert_slt_upper_clear_R5: assert (result[WIDTH-1:1] == '0);
            assert_slt_signed_R5: assert (result[0] == ($signed(op_a) < $signed(op_b)));
        end
        if (ctrl == 4'b0010) begin
            assert_add_overflow_R8: assert (overflow ==
                ((op_a[WIDTH-1] == op_b[WIDTH-1]) && (result[WIDTH-1] != op_a[WIDTH-1])));
        end
        if (ctrl == 4'b0110) begin
            assert_sub_value_R4: assert (result == op_a - op_b);
        end
    end
endmodule

bind sliced_alu sliced_alu_props #(.WIDTH(WIDTH)) u_props (
    .op_a     (op_a),
    .op_b     (op_b),
    .ctrl     (ctrl),
    .result   (result),
    .zero     (zero),
    .overflow (overflow)
);

// File: tb/sliced_alu_tb.sv
module sliced_alu_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    typedef struct packed {
        logic [3:0]   ctrl;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] res;
        logic         z;
        logic         v;
        logic [7:0]   req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{4'b0000, 32'hF0F0F0F0, 32'h0FF00FF0, 32'h00F000F0, 1'b0, 1'b0, 8'd1},  // R1
        '{4'b0000, 32'hAAAAAAAA, 32'h55555555, 32'h00000000, 1'b1, 1'b0, 8'd1},  // R1 R7
        '{4'b0001, 32'hF0F0F0F0, 32'h0F0F0F0F, 32'hFFFFFFFF, 1'b0, 1'b0, 8'd2},  // R2
        '{4'b0010, 32'h00000005, 32'h00000003, 32'h00000008, 1'b0, 1'b0, 8'd3},  // R3
        '{4'b0010, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b0, 8'd3},  // R3 full ripple
        '{4'b0010, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 1'b1, 8'd8},  // R8
        '{4'b0010, 32'h80000000, 32'h80000000, 32'h00000000, 1'b1, 1'b1, 8'd8},  // R8
        '{4'b0110, 32'h0000000A, 32'h00000003, 32'h00000007, 1'b0, 1'b0, 8'd4},  // R4
        '{4'b0110, 32'h00000005, 32'h00000005, 32'h00000000, 1'b1, 1'b0, 8'd4},  // R4 R7
        '{4'b0110, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b0, 1'b1, 8'd9},  // R9
        '{4'b0110, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h80000000, 1'b0, 1'b1, 8'd9},  // R9
        '{4'b0111, 32'hFFFFFFFF, 32'h00000001, 32'h00000001, 1'b0, 1'b0, 8'd5},  // R5
        '{4'b0111, 32'h00000001, 32'hFFFFFFFF, 32'h00000000, 1'b1, 1'b0, 8'd5},  // R5
        '{4'b0111, 32'h80000000, 32'h7FFFFFFF, 32'h00000001, 1'b0, 1'b0, 8'd5},  // R5 overflowing compare
        '{4'b0111, 32'h7FFFFFFF, 32'h80000000, 32'h00000000, 1'b1, 1'b0, 8'd5},  // R5 R10
        '{4'b1100, 32'hF0F0F0F0, 32'h0F0F0000, 32'h00000F0F, 1'b0, 1'b0, 8'd6},  // R6
        '{4'b1100, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 1'b0, 1'b0, 8'd6},  // R6
        '{4'b1010, 32'h00000005, 32'h00000009, 32'h00000003, 1'b0, 1'b0, 8'd11}, // R11
        '{4'b0100, 32'hFF00FF00, 32'h0F0F0F0F, 32'hF000F000, 1'b0, 1'b0, 8'd11}, // R11
        '{4'b0001, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 1'b0, 1'b0, 8'd10}  // R10
    };

    logic         clk = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [3:0]   ctrl = '0;
    logic [W-1:0] result;
    logic         zero;
    logic         overflow;
    int           checks = 0;
    int           errors = 0;
    logic         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sliced_alu dut_i (
        .op_a     (op_a),
        .op_b     (op_b),
        .ctrl     (ctrl),
        .result   (result),
        .zero     (zero),
        .overflow (overflow)
    );

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h (ctrl=%b a=%h b=%h)", tag, got, exp, ctrl, op_a, op_b);
        end
    endtask

    // Inputs change on a rising edge; outputs are sampled on the falling edge.
    task automatic apply(input logic [3:0] c, input logic [W-1:0] a, input logic [W-1:0] b);
        @(posedge clk);
        ctrl = c;
        op_a = a;
        op_b = b;
        @(negedge clk);
    endtask

    initial begin
        // Idle inputs (all zero, AND): result 0, zero set, no overflow.
        apply(4'b0000, '0, '0);
        check("R7 idle result", result, '0);
        check("R7 idle zero", {31'b0, zero}, 32'd1);
        check("R10 idle ovf", {31'b0, overflow}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].ctrl, VECS[i].a, VECS[i].b);
            check($sformatf("R%0d vec%0d result", VECS[i].req, i), result, VECS[i].res);
            check($sformatf("R7 vec%0d zero", i), {31'b0, zero}, {31'b0, VECS[i].z});
            check($sformatf("R%0d vec%0d ovf", VECS[i].req, i), {31'b0, overflow}, {31'b0, VECS[i].v});
        end

        // R5: signed compare against a model on a spread of operand pairs.
        for (int i = 0; i < 16; i++) begin
            logic [W-1:0] a, b;
            a = 32'h9E3779B9 * (i + 1);
            b = 32'h7F4A7C15 * (i + 3);
            apply(4'b0111, a, b);
            check("R5 slt sweep", result, {31'b0, ($signed(a) < $signed(b))});
            check("R10 slt sweep ovf", {31'b0, overflow}, 32'd0);
        end

        // R3/R8: addition against a model.
        for (int i = 0; i < 16; i++) begin
            logic [W-1:0] a, b, s;
            a = 32'hC2B2AE35 * (i + 5);
            b = 32'h27D4EB2F * (i + 7);
            s = a + b;
            apply(4'b0010, a, b);
            check("R3 add sweep", result, s);
            check("R8 add sweep ovf", {31'b0, overflow},
                  {31'b0, (a[W-1] == b[W-1]) && (s[W-1] != a[W-1])});
        end

        // R9: subtraction overflow against a model.
        for (int i = 0; i < 16; i++) begin
            logic [W-1:0] a, b, d;
            a = 32'h85EBCA6B * (i + 2);
            b = 32'h165667B1 * (i + 9);
            d = a - b;
            apply(4'b0110, a, b);
            check("R4 sub sweep", result, d);
            check("R9 sub sweep ovf", {31'b0, overflow},
                  {31'b0, (a[W-1] != b[W-1]) && (d[W-1] != a[W-1])});
        end

        // R7: a single set bit anywhere clears the zero flag.
        for (int i = 0; i < W; i++) begin
            apply(4'b0000, 32'h1 << i, 32'h1 << i);
            check("R7 walking bit zero", {31'b0, zero}, 32'd0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule